// File: doc/BRIEF.md
# Ping-Pong Channel Deinterleave Buffer

This block generates the memory-side addresses for a multichannel time-division serial link. Words arrive in slot order: one word for each channel, then the same again for the next frame. The block writes each word into a channel-major receive buffer, so that all samples of one channel occupy a contiguous run of addresses. In the same slot it produces the read address of the matching transmit buffer, so that channel-major output data leaves in interleaved slot order. The serial side is a single fixed data register. Only the memory-side address moves.

Each direction has two buffers, bank 0 and bank 1. While the serial side fills and drains one bank, the processor works on the other bank's receive and transmit pair. When the last slot of a buffer has been handled, both directions switch to the other bank at once, with no software action. A one-cycle interrupt pulse reports which bank is now ready for the processor. A pending flag stays set until the processor acknowledges it. If a further buffer completes before that acknowledge, an overrun flag is raised and the swap still takes place.

Within a bank, sample `s` of channel `c` sits at offset `c*FRAMES + s`. Bank 1 starts at address `CHANNELS*FRAMES`. While a frame is in progress the address rises by `FRAMES` per slot. At the end of a frame it falls by `FRAMES*(CHANNELS-1)` and then rises by one.

Top module: `pingpong_deinterleave`

## Requirements
- R1: After reset the next slot address is 0 (bank 0, channel 0, sample 0), and `irq`, `pending`, `overrun` and `ready_bank` are all 0.
- R2: Within a frame, each accepted slot (`slot_en`=1) advances the address by `FRAMES`, so slot `c` of sample `s` is written at bank base + `c*FRAMES + s`.
- R3: After the slot of the last channel in a frame, the next address is bank base + (s+1), the next sample of channel 0.
- R4: `rx_wr_en` equals `slot_en` and `rx_wr_data` equals `slot_data`. Cycles with `slot_en`=0 leave the address unchanged.
- R5: After the last slot of a buffer (channel `CHANNELS-1`, sample `FRAMES-1`), the bank toggles and the next address is the base of the other bank (0 or `CHANNELS*FRAMES`).
- R6: In the cycle after a buffer's last slot, `irq` is 1 for exactly one cycle, and `ready_bank` holds the bank that was just completed.
- R7: `tx_rd_en` and `tx_rd_addr` equal `rx_wr_en` and `rx_wr_addr` in every cycle, so each output buffer pairs with the input buffer of the same bank and both swap on the same slot.
- R8: `pending` becomes 1 when a buffer completes and returns to 0 after a cycle with `irq_ack`=1 and no completion. That acknowledge also clears `overrun`.
- R9: If a buffer completes while `pending` is 1 and `irq_ack` is 0, `overrun` becomes 1, the bank still toggles and `irq` still pulses.
- R10: If a completion and `irq_ack` coincide, `pending` stays 1 and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One serial slot is handled this cycle |
| slot_data | input | WORD_W | Received word for this slot |
| irq_ack | input | 1 | Processor acknowledges the ready bank |
| rx_wr_en | output | 1 | Receive memory write strobe |
| rx_wr_addr | output | AW | Receive memory write address |
| rx_wr_data | output | WORD_W | Receive memory write data |
| tx_rd_en | output | 1 | Transmit memory read strobe |
| tx_rd_addr | output | AW | Transmit memory read address |
| irq | output | 1 | One-cycle buffer-complete pulse |
| ready_bank | output | 1 | Bank the processor may now use |
| pending | output | 1 | Completion not yet acknowledged |
| overrun | output | 1 | A completion arrived while one was still pending |

## Verification
The bench compares every slot address against an independent model of the channel-major layout. This catches a design that forgets the backward jump at the end of a frame and runs past the buffer, and one that is off by one sample when it jumps. It inserts idle gaps inside a buffer to catch an address that drifts while no slot is accepted. It also crosses bank boundaries twice, to catch a bank that does not toggle or an offset that does not return to zero. On the interrupt side it targets three cases: a completion while a previous one is unacknowledged, which must raise overrun but still swap; an acknowledge that lands on the completion cycle, which must leave pending set without an overrun; and an interrupt that is held for more than one cycle.

// File: rtl/pingpong_deinterleave_pkg.sv
package pingpong_deinterleave_pkg;

    // Registered interrupt-side state
    typedef struct packed {
        logic bank;
        logic irq;
        logic ready_bank;
        logic pending;
        logic overrun;
    } evt_state_t;

endpackage

// File: rtl/pp_slot_counter.sv
module pp_slot_counter #(
    parameter int CHANNELS = 4,
    parameter int FRAMES   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic frame_end,
    output logic buf_end
);
    localparam int CW = $clog2(CHANNELS > 1 ? CHANNELS : 2);
    localparam int SW = $clog2(FRAMES > 1 ? FRAMES : 2);
    localparam logic [CW-1:0] CH_LAST = CW'(CHANNELS - 1);
    localparam logic [SW-1:0] SM_LAST = SW'(FRAMES - 1);

    typedef struct packed {
        logic [CW-1:0] ch;
        logic [SW-1:0] smp;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    assign frame_end = adv && (ctr_q.ch == CH_LAST);
    assign buf_end   = frame_end && (ctr_q.smp == SM_LAST);

    always_comb begin
        ctr_d = ctr_q;
        if (adv) begin
            if (ctr_q.ch == CH_LAST) begin
                ctr_d.ch  = '0;
                ctr_d.smp = (ctr_q.smp == SM_LAST) ? '0 : ctr_q.smp + SW'(1);
            end else begin
                ctr_d.ch = ctr_q.ch + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end
endmodule

// File: rtl/pp_addr_step.sv
module pp_addr_step #(
    parameter int CHANNELS = 4,
    parameter int FRAMES   = 8,
    localparam int OW      = $clog2(CHANNELS * FRAMES > 1 ? CHANNELS * FRAMES : 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          frame_end,
    input  logic          buf_end,
    output logic [OW-1:0] offset
);
    localparam int BACK = FRAMES * (CHANNELS - 1);

    logic [OW-1:0] off_d, off_q;

    // Two-dimensional step: +FRAMES per element, wrap back per frame
    always_comb begin
        off_d = off_q;
        if (adv) begin
            if (buf_end)        off_d = '0;
            else if (frame_end) off_d = off_q + OW'(1) - OW'(BACK);
            else                off_d = off_q + OW'(FRAMES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign offset = off_q;
endmodule

// File: rtl/pp_event_ctl.sv
module pp_event_ctl
    import pingpong_deinterleave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic buf_end,
    input  logic ack,
    output logic bank,
    output logic irq,
    output logic ready_bank,
    output logic pending,
    output logic overrun
);
    evt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = buf_end;
        if (buf_end) begin
            st_d.bank       = ~st_q.bank;
            st_d.ready_bank = st_q.bank;
            st_d.pending    = 1'b1;
            if (ack)               st_d.overrun = 1'b0;
            else if (st_q.pending) st_d.overrun = 1'b1;
        end else if (ack) begin
            st_d.pending = 1'b0;
            st_d.overrun = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank       = st_q.bank;
    assign irq        = st_q.irq;
    assign ready_bank = st_q.ready_bank;
    assign pending    = st_q.pending;
    assign overrun    = st_q.overrun;
endmodule

// File: rtl/pingpong_deinterleave.sv
module pingpong_deinterleave #(
    parameter int CHANNELS = 4,
    parameter int FRAMES   = 8,
    parameter int WORD_W   = 16,
    localparam int BUF_WORDS = CHANNELS * FRAMES,
    localparam int AW        = $clog2(2 * BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic [WORD_W-1:0] slot_data,
    input  logic              irq_ack,
    output logic              rx_wr_en,
    output logic [AW-1:0]     rx_wr_addr,
    output logic [WORD_W-1:0] rx_wr_data,
    output logic              tx_rd_en,
    output logic [AW-1:0]     tx_rd_addr,
    output logic              irq,
    output logic              ready_bank,
    output logic              pending,
    output logic              overrun
);
    localparam int OW = $clog2(BUF_WORDS > 1 ? BUF_WORDS : 2);

    logic          frame_end, buf_end, bank;
    logic [OW-1:0] offset;
    logic [AW-1:0] addr;

    pp_slot_counter #(.CHANNELS(CHANNELS), .FRAMES(FRAMES)) ctr_i (
        .clk(clk), .rst_n(rst_n), .adv(slot_en),
        .frame_end(frame_end), .buf_end(buf_end)
    );

    pp_addr_step #(.CHANNELS(CHANNELS), .FRAMES(FRAMES)) step_i (
        .clk(clk), .rst_n(rst_n), .adv(slot_en),
        .frame_end(frame_end), .buf_end(buf_end), .offset(offset)
    );

    pp_event_ctl evt_i (
        .clk(clk), .rst_n(rst_n), .buf_end(buf_end), .ack(irq_ack),
        .bank(bank), .irq(irq), .ready_bank(ready_bank),
        .pending(pending), .overrun(overrun)
    );

    always_comb begin
        addr = AW'(offset);
        if (bank) addr = addr + AW'(BUF_WORDS);
    end

    assign rx_wr_en   = slot_en;
    assign rx_wr_addr = addr;
    assign rx_wr_data = slot_data;
    assign tx_rd_en   = slot_en;
    assign tx_rd_addr = addr;
endmodule

// File: rtl/pingpong_deinterleave_chk.sv
module pingpong_deinterleave_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_en,
    input logic          irq_ack,
    input logic          rx_wr_en,
    input logic [AW-1:0] rx_wr_addr,
    input logic          tx_rd_en,
    input logic [AW-1:0] tx_rd_addr,
    input logic          irq,
    input logic          pending,
    input logic          overrun
);
    // R6
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6
    irq_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(slot_en));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(rx_wr_addr));

    // R7
    tx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rd_addr == rx_wr_addr) && (tx_rd_en == rx_wr_en));

    // R8
    pending_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> irq);

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(pending) && !$past(irq_ack)) |-> overrun);

    // R10
    ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq_ack)) |-> (pending && !overrun));
endmodule

bind pingpong_deinterleave pingpong_deinterleave_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .irq_ack(irq_ack),
    .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr),
    .tx_rd_en(tx_rd_en), .tx_rd_addr(tx_rd_addr),
    .irq(irq), .pending(pending), .overrun(overrun)
);

// File: tb/pingpong_deinterleave_tb_top.sv
`timescale 1ns/1ps
module pingpong_deinterleave_tb_top;
    localparam int CH   = 4;
    localparam int LEN  = 8;
    localparam int W    = 16;
    localparam int BUFW = CH * LEN;
    localparam int AW   = $clog2(2 * BUFW);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          slot_en;
    logic [W-1:0]  slot_data;
    logic          irq_ack;
    logic          rx_wr_en, tx_rd_en;
    logic [AW-1:0] rx_wr_addr, tx_rd_addr;
    logic [W-1:0]  rx_wr_data;
    logic          irq, ready_bank, pending, overrun;

    int checks = 0;
    int failures = 0;
    int mbank = 0, mch = 0, ms = 0;

    always #2.5 clk = ~clk;

    pingpong_deinterleave #(.CHANNELS(CH), .FRAMES(LEN), .WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_data(slot_data),
        .irq_ack(irq_ack), .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr),
        .rx_wr_data(rx_wr_data), .tx_rd_en(tx_rd_en), .tx_rd_addr(tx_rd_addr),
        .irq(irq), .ready_bank(ready_bank), .pending(pending), .overrun(overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_addr();
        return mbank * BUFW + mch * LEN + ms;
    endfunction

    // One accepted slot; checks address, data path and interrupt pulse
    task automatic slot(input logic [W-1:0] d, input logic ack);
        bit last;
        slot_en = 1'b1; slot_data = d; irq_ack = ack;
        #1;
        if (mch == 0 && ms == 0) check("R5 bank base address", int'(rx_wr_addr), exp_addr());
        else if (mch == 0)       check("R3 frame wrap address", int'(rx_wr_addr), exp_addr());
        else                     check("R2 element step address", int'(rx_wr_addr), exp_addr());
        check("R7 tx address pairs", int'(tx_rd_addr), int'(rx_wr_addr));
        check("R7 tx strobe", int'(tx_rd_en), 1);
        check("R4 write data", int'(rx_wr_data), int'(d));
        check("R4 write strobe", int'(rx_wr_en), 1);
        last = (mch == CH - 1) && (ms == LEN - 1);
        @(posedge clk); #1;
        slot_en = 1'b0; irq_ack = 1'b0;
        if (last) begin
            check("R6 irq pulse", int'(irq), 1);
            check("R6 ready bank", int'(ready_bank), mbank);
            mbank = 1 - mbank; mch = 0; ms = 0;
        end else begin
            check("R6 irq quiet", int'(irq), 0);
            if (mch == CH - 1) begin mch = 0; ms++; end
            else mch++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check("R4 no advance when idle", int'(rx_wr_addr), exp_addr());
            check("R4 strobe low when idle", int'(rx_wr_en), 0);
        end
    endtask

    task automatic fill(input bit ack_last, input bit gaps, input int seed);
        for (int i = 0; i < BUFW; i++) begin
            if (gaps && (i % 5 == 2)) idle(2);
            slot(W'(seed * 97 + i * 13), (ack_last && i == BUFW - 1) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic test_reset();
        check("R1 reset address", int'(rx_wr_addr), 0);
        check("R1 reset irq", int'(irq), 0);
        check("R1 reset pending", int'(pending), 0);
        check("R1 reset overrun", int'(overrun), 0);
        check("R1 reset ready bank", int'(ready_bank), 0);
    endtask

    task automatic test_first_buffer();
        fill(1'b0, 1'b0, 1);
        check("R8 pending after completion", int'(pending), 1);
        check("R9 no overrun on first", int'(overrun), 0);
        @(posedge clk); #1;
        check("R6 irq single cycle", int'(irq), 0);
    endtask

    task automatic test_overrun();
        fill(1'b0, 1'b1, 2);
        check("R9 overrun raised", int'(overrun), 1);
        check("R9 swap proceeds", int'(rx_wr_addr), 0);
        check("R9 pending kept", int'(pending), 1);
    endtask

    task automatic test_ack();
        irq_ack = 1'b1;
        @(posedge clk); #1;
        irq_ack = 1'b0;
        check("R8 pending cleared by ack", int'(pending), 0);
        check("R8 overrun cleared by ack", int'(overrun), 0);
        check("R8 address unaffected by ack", int'(rx_wr_addr), exp_addr());
    endtask

    task automatic test_ack_collide();
        fill(1'b0, 1'b0, 3);
        check("R8 pending set", int'(pending), 1);
        fill(1'b1, 1'b0, 4);
        check("R10 pending stays set", int'(pending), 1);
        check("R10 no overrun", int'(overrun), 0);
        check("R10 ready bank", int'(ready_bank), 1);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; slot_en = 1'b0; slot_data = '0; irq_ack = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        test_reset();
        test_first_buffer();
        test_overrun();
        test_ack();
        test_ack_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule